// File: doc/BRIEF.md
# Clock and Reset Control Register Bank

This block is the software-visible state of a clock and reset unit. It stores PLL configuration words, one PLL mode word, clock select/divider words, clock-gate words and soft-reset words. It drives their values as flat vectors to the PLLs, muxes, gates and reset synchronisers elsewhere on the chip. It does not build any of those.

Every write is masked. The upper half of the 32-bit write data is a per-bit enable for the lower half. Software can therefore flip one field, or one reset line, in a single write and never needs a read-modify-write. Reads return the stored half-word with the upper half zero. Requests arrive on a valid/ready bus that accepts one request in every cycle. A read answers one cycle later with a response valid pulse.

Top module: `clkrst_regs`

## Requirements
- R1: On an accepted write to a mapped word, data bit i (0..15) is stored only where data bit i+16 is 1. Every other stored bit keeps its value, so a write with an all-zero upper half changes nothing.
- R2: `req_ready` is always high. An accepted read (`req_valid`=1, `req_write`=0) gives `rsp_valid`=1 in the next cycle only. `rsp_rdata` then holds the stored word in bits 15:0 and zero in bits 31:16.
- R3: PLL p (0..N_PLL-1) owns byte offsets 0x20*p + 4*w for w < PLL_WORDS. That word drives `pll_cfg[(p*PLL_WORDS+w)*16 +: 16]`.
- R4: The mode word sits at offset 0xA0. PLL p has the 2-bit field at bits 2p+1:2p, and that field drives `pll_mode[2p +: 2]`. The codes are 0 = slow (reference clock), 1 = normal and 2 = deep. Bits at 2*N_PLL and above read as zero and ignore writes.
- R5: Select/divider word i (i < SEL_WORDS) is at offset 0x100 + 4*i and drives `clk_sel[i*16 +: 16]`.
- R6: Gate word i (i < GATE_WORDS) is at offset 0x300 + 4*i and drives `clk_gate[i*16 +: 16]`. After reset all gate bits are 0, which means every clock is enabled.
- R7: Soft-reset word k (k < RST_WORDS) is at offset 0x400 + 4*k. Line n is `soft_rst[n]`, and bit n mod 16 of word n/16 controls it. Writing 1 asserts the line and writing 0 releases it.
- R8: An offset that is not 4-byte aligned, or that lies outside every mapped word, reads as zero. A write to such an offset changes no output.
- R9: With `rst_n` low at a clock edge, every stored word, `rsp_valid` and `rsp_rdata` clear to zero at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write enables in 31:16, data in 15:0 |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pll_cfg | output | N_PLL*PLL_WORDS*16 | PLL configuration words |
| pll_mode | output | 2*N_PLL | PLL mode codes |
| clk_sel | output | SEL_WORDS*16 | Select/divider words |
| clk_gate | output | GATE_WORDS*16 | Clock-gate words |
| soft_rst | output | RST_WORDS*16 | Soft-reset lines |

## Verification
The bench builds the bank with four PLLs of three words each, four select words, two gate words and two soft-reset words. At that size the whole 4 KiB offset space, 1024 aligned words, can be written and then read back in several rounds with changing masks. Every gap, every bank boundary and every word just past a bank's last word is therefore hit. The small reset bank lets the bench drive each of the 32 soft-reset lines on its own and also sweep every mode code.

// File: rtl/clkrst_pkg.sv
// Shared constants and types for the clock/reset register bank.
// Assumes a byte-addressed map with 32-bit words at a 4-byte stride.
package clkrst_pkg;
    localparam int FIELD_W    = 16;   // stored half of each word
    localparam int BUS_W      = 2 * FIELD_W;
    localparam int IDX_W      = 8;    // word index within one group
    localparam int PLL_BASE   = 'h000;
    localparam int PLL_STRIDE = 'h020;
    localparam int MODE_OFS   = 'h0A0;
    localparam int SEL_BASE   = 'h100;
    localparam int GATE_BASE  = 'h300;
    localparam int RST_BASE   = 'h400;

    typedef enum logic [2:0] {
        RG_NONE, RG_PLL, RG_MODE, RG_SEL, RG_GATE, RG_RST
    } region_e;
endpackage

// File: rtl/clkrst_addr_dec.sv
// Address decoder: maps a byte offset to a register group and a word index.
// Assumes N_PLL <= 4, PLL_WORDS <= 8, SEL_WORDS <= 128, GATE_WORDS <= 64, so
// that no group overlaps the next one. Unaligned offsets decode to RG_NONE.
module clkrst_addr_dec
    import clkrst_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int N_PLL      = 4,
    parameter int PLL_WORDS  = 3,
    parameter int SEL_WORDS  = 48,
    parameter int GATE_WORDS = 15,
    parameter int RST_WORDS  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx
);
    localparam int PLL_END  = PLL_BASE + N_PLL * PLL_STRIDE;
    localparam int SEL_END  = SEL_BASE + 4 * SEL_WORDS;
    localparam int GATE_END = GATE_BASE + 4 * GATE_WORDS;
    localparam int RST_END  = RST_BASE + 4 * RST_WORDS;

    // Classify the offset into a group and word index.
    always_comb begin
        int a;
        int slot;
        a      = int'(addr);
        slot   = 0;
        region = RG_NONE;
        idx    = '0;
        if (a % 4 == 0) begin
            if (a < PLL_END) begin
                slot = ((a - PLL_BASE) % PLL_STRIDE) / 4;
                if (slot < PLL_WORDS) begin
                    region = RG_PLL;
                    idx    = IDX_W'(((a - PLL_BASE) / PLL_STRIDE) * PLL_WORDS + slot);
                end
            end else if (a == MODE_OFS) begin
                region = RG_MODE;
            end else if (a >= SEL_BASE && a < SEL_END) begin
                region = RG_SEL;
                idx    = IDX_W'((a - SEL_BASE) / 4);
            end else if (a >= GATE_BASE && a < GATE_END) begin
                region = RG_GATE;
                idx    = IDX_W'((a - GATE_BASE) / 4);
            end else if (a >= RST_BASE && a < RST_END) begin
                region = RG_RST;
                idx    = IDX_W'((a - RST_BASE) / 4);
            end
        end
    end
endmodule

// File: rtl/clkrst_mreg.sv
// One bit-masked storage word: each bit loads data only where its enable is set.
// Assumes the caller qualifies wr_en with decode and bus acceptance.
module clkrst_mreg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] wmask,
    output logic [WIDTH-1:0] q
);
    // Clear on reset, otherwise merge enabled data bits into the stored value.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= (q & ~wmask) | (wdata & wmask);
    end

    // R1: bits without an enable never move on a write
    p_unmasked_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((q ^ $past(q)) & ~$past(wmask)) == '0));
    // R1: enabled bits take the written data
    p_masked_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q & $past(wmask)) == ($past(wdata) & $past(wmask))));
    // R8: without a write the word holds
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/clkrst_regs.sv
// Clock/reset control register bank with masked writes and one-cycle reads.
// Assumes one request per cycle is always accepted; outputs are the raw
// stored fields, with no synchronisation toward the consuming clock domains.
module clkrst_regs
    import clkrst_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int N_PLL      = 4,
    parameter int PLL_WORDS  = 3,
    parameter int SEL_WORDS  = 48,
    parameter int GATE_WORDS = 15,
    parameter int RST_WORDS  = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic                                req_write,
    input  logic [ADDR_W-1:0]                   req_addr,
    input  logic [31:0]                         req_wdata,
    output logic                                rsp_valid,
    output logic [31:0]                         rsp_rdata,
    output logic [N_PLL*PLL_WORDS*FIELD_W-1:0]  pll_cfg,
    output logic [2*N_PLL-1:0]                  pll_mode,
    output logic [SEL_WORDS*FIELD_W-1:0]        clk_sel,
    output logic [GATE_WORDS*FIELD_W-1:0]       clk_gate,
    output logic [RST_WORDS*FIELD_W-1:0]        soft_rst
);
    localparam int PLL_TOTAL = N_PLL * PLL_WORDS;
    localparam int MODE_W    = 2 * N_PLL;

    region_e              region;
    logic [IDX_W-1:0]     idx;
    logic                 wr_acc;
    logic                 rd_acc;
    logic [FIELD_W-1:0]   wr_data;
    logic [FIELD_W-1:0]   wr_mask;
    logic [FIELD_W-1:0]   rd_half;
    logic [FIELD_W-1:0]   pll_q  [PLL_TOTAL];
    logic [FIELD_W-1:0]   sel_q  [SEL_WORDS];
    logic [FIELD_W-1:0]   gate_q [GATE_WORDS];
    logic [FIELD_W-1:0]   rst_q  [RST_WORDS];
    logic [MODE_W-1:0]    mode_q;

    assign req_ready = 1'b1;
    assign wr_acc    = req_valid && req_write;
    assign rd_acc    = req_valid && !req_write;
    assign wr_data   = req_wdata[FIELD_W-1:0];
    assign wr_mask   = req_wdata[BUS_W-1:FIELD_W];

    clkrst_addr_dec #(
        .ADDR_W(ADDR_W), .N_PLL(N_PLL), .PLL_WORDS(PLL_WORDS),
        .SEL_WORDS(SEL_WORDS), .GATE_WORDS(GATE_WORDS), .RST_WORDS(RST_WORDS)
    ) dec_i (
        .addr(req_addr), .region(region), .idx(idx)
    );

    for (genvar i = 0; i < PLL_TOTAL; i++) begin : g_pll
        clkrst_mreg #(.WIDTH(FIELD_W)) word_i (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_acc && region == RG_PLL && int'(idx) == i),
            .wdata(wr_data), .wmask(wr_mask), .q(pll_q[i]));
        assign pll_cfg[i*FIELD_W +: FIELD_W] = pll_q[i];
    end

    clkrst_mreg #(.WIDTH(MODE_W)) mode_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_acc && region == RG_MODE),
        .wdata(wr_data[MODE_W-1:0]), .wmask(wr_mask[MODE_W-1:0]), .q(mode_q));
    assign pll_mode = mode_q;

    for (genvar i = 0; i < SEL_WORDS; i++) begin : g_sel
        clkrst_mreg #(.WIDTH(FIELD_W)) word_i (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_acc && region == RG_SEL && int'(idx) == i),
            .wdata(wr_data), .wmask(wr_mask), .q(sel_q[i]));
        assign clk_sel[i*FIELD_W +: FIELD_W] = sel_q[i];
    end

    for (genvar i = 0; i < GATE_WORDS; i++) begin : g_gate
        clkrst_mreg #(.WIDTH(FIELD_W)) word_i (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_acc && region == RG_GATE && int'(idx) == i),
            .wdata(wr_data), .wmask(wr_mask), .q(gate_q[i]));
        assign clk_gate[i*FIELD_W +: FIELD_W] = gate_q[i];
    end

    for (genvar i = 0; i < RST_WORDS; i++) begin : g_rst
        clkrst_mreg #(.WIDTH(FIELD_W)) word_i (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_acc && region == RG_RST && int'(idx) == i),
            .wdata(wr_data), .wmask(wr_mask), .q(rst_q[i]));
        assign soft_rst[i*FIELD_W +: FIELD_W] = rst_q[i];
    end

    // Select the stored half-word addressed by the current request.
    always_comb begin
        rd_half = '0;
        unique case (region)
            RG_PLL:  for (int i = 0; i < PLL_TOTAL; i++)  if (int'(idx) == i) rd_half = pll_q[i];
            RG_MODE: rd_half = FIELD_W'(mode_q);
            RG_SEL:  for (int i = 0; i < SEL_WORDS; i++)  if (int'(idx) == i) rd_half = sel_q[i];
            RG_GATE: for (int i = 0; i < GATE_WORDS; i++) if (int'(idx) == i) rd_half = gate_q[i];
            RG_RST:  for (int i = 0; i < RST_WORDS; i++)  if (int'(idx) == i) rd_half = rst_q[i];
            default: rd_half = '0;
        endcase
    end

    // Register the read response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_acc;
            rsp_rdata <= rd_acc ? {{FIELD_W{1'b0}}, rd_half} : '0;
        end
    end

    // R2: every accepted read is answered in the next cycle
    p_rsp_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rsp_valid);
    // R2: no response without a read one cycle before
    p_rsp_only_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rd_acc));
    // R8: unmapped reads return zero
    p_unmapped_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && region == RG_NONE) |=> (rsp_rdata == '0));
    // R8: unmapped writes leave every output unchanged
    p_unmapped_write_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && region == RG_NONE) |=> ($stable(pll_cfg) && $stable(pll_mode) &&
            $stable(clk_sel) && $stable(clk_gate) && $stable(soft_rst)));
endmodule

// File: tb/clkrst_regs_tb_top.sv
// Sweep bench: the whole offset space is written and read in several rounds
// against an arithmetic shadow model built from the requirements.
module clkrst_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int NP = 4, PW = 3, NS = 4, NG = 2, NR = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic [NP*PW*16-1:0] pll_cfg;
    logic [2*NP-1:0] pll_mode;
    logic [NS*16-1:0] clk_sel;
    logic [NG*16-1:0] clk_gate;
    logic [NR*16-1:0] soft_rst;

    int n_checks = 0, n_fail = 0;
    logic [15:0] model [1024];

    always #(CLK_PERIOD/2) clk = ~clk;

    clkrst_regs #(.ADDR_W(AW), .N_PLL(NP), .PLL_WORDS(PW), .SEL_WORDS(NS),
                  .GATE_WORDS(NG), .RST_WORDS(NR)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pll_cfg(pll_cfg),
        .pll_mode(pll_mode), .clk_sel(clk_sel), .clk_gate(clk_gate),
        .soft_rst(soft_rst));

    // Writable bits of the word at byte offset a (zero when unmapped).
    function automatic logic [15:0] wmask_of(int a);
        if (a % 4 != 0) return 16'h0;
        if (a < 32 * NP) return ((a % 32) / 4 < PW) ? 16'hFFFF : 16'h0;
        if (a == 'hA0) return 16'((1 << (2 * NP)) - 1);
        if (a >= 'h100 && a < 'h100 + 4 * NS) return 16'hFFFF;
        if (a >= 'h300 && a < 'h300 + 4 * NG) return 16'hFFFF;
        if (a >= 'h400 && a < 'h400 + 4 * NR) return 16'hFFFF;
        return 16'h0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [31:0] d);
        logic [15:0] m;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        m = d[31:16] & wmask_of(a);
        if (a % 4 == 0)
            model[a / 4] = (model[a / 4] & ~m) | (d[15:0] & m);
    endtask

    task automatic do_read(input int a, input string req);
        logic [31:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        @(negedge clk);
        req_valid = 1'b0;
        exp = (wmask_of(a) != 0) ? {16'h0, model[a / 4]} : 32'h0;
        check(rsp_valid === 1'b1, "R2 rsp_valid", 256'(rsp_valid), 256'(1));
        check(rsp_rdata === exp, req, 256'(rsp_rdata), 256'(exp));
    endtask

    task automatic check_outputs();
        logic [NP*PW*16-1:0] ep;
        logic [NS*16-1:0] es;
        logic [NG*16-1:0] eg;
        logic [NR*16-1:0] er;
        for (int p = 0; p < NP; p++)
            for (int w = 0; w < PW; w++)
                ep[(p*PW+w)*16 +: 16] = model[(p*32 + w*4) / 4];
        for (int i = 0; i < NS; i++) es[i*16 +: 16] = model[('h100 + 4*i) / 4];
        for (int i = 0; i < NG; i++) eg[i*16 +: 16] = model[('h300 + 4*i) / 4];
        for (int i = 0; i < NR; i++) er[i*16 +: 16] = model[('h400 + 4*i) / 4];
        check(pll_cfg === ep, "R3 pll_cfg", 256'(pll_cfg), 256'(ep));
        check(pll_mode === model['hA0/4][2*NP-1:0], "R4 pll_mode", 256'(pll_mode),
              256'(model['hA0/4][2*NP-1:0]));
        check(clk_sel === es, "R5 clk_sel", 256'(clk_sel), 256'(es));
        check(clk_gate === eg, "R6 clk_gate", 256'(clk_gate), 256'(eg));
        check(soft_rst === er, "R7 soft_rst", 256'(soft_rst), 256'(er));
    endtask

    task automatic clear_model();
        for (int i = 0; i < 1024; i++) model[i] = 16'h0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        check(req_ready === 1'b1, "R2 req_ready", 256'(req_ready), 256'(1));
        rst_n = 1'b1;
        // R9 / R6: reset state, gates all zero (every clock enabled)
        check(rsp_valid === 1'b0, "R9 rsp_valid", 256'(rsp_valid), 256'(0));
        check_outputs();
        do_read('h300, "R6 gate reset read");

        // Full sweeps with changing masks (R1, R2, R3..R8)
        for (int r = 0; r < 3; r++) begin
            for (int a = 0; a < 4096; a += 4) begin
                logic [15:0] m, v;
                m = 16'(a * 'h9E37 + r * 'h3C6B + 'h5555);
                v = 16'(~((a * 'h1F3) ^ (r * 'h7777)));
                do_write(a, {m, v});
            end
            check_outputs();
            for (int a = 0; a < 4096; a += 4)
                do_read(a, (wmask_of(a) != 0) ? "R1 R2 mapped readback" : "R8 unmapped read");
        end

        // R1: zero mask changes nothing, full mask replaces the word
        do_write('h104, 32'h0000_BEEF);
        do_read('h104, "R1 zero mask");
        do_write('h104, 32'hFFFF_1234);
        do_read('h104, "R1 full mask");
        do_write('h104, 32'h00F0_FFFF);
        do_read('h104, "R1 nibble mask");

        // R8: unaligned offsets neither write nor read
        for (int off = 1; off < 4; off++) begin
            do_write('h104 + off, 32'hFFFF_0000);
            do_read('h104 + off, "R8 unaligned read");
        end
        do_read('h104, "R8 unaligned write ignored");
        check_outputs();

        // R4: codes 0 slow, 1 normal, 2 deep, 3 per field; upper bits dropped
        do_write('hA0, 32'hFFFF_FF00);
        check(pll_mode === 8'h00, "R4 all slow", 256'(pll_mode), 256'(8'h00));
        do_write('hA0, 32'hFFFF_FF64);
        check(pll_mode === 8'h64, "R4 mixed codes", 256'(pll_mode), 256'(8'h64));
        check(pll_mode[5:4] === 2'd2, "R4 pll2 deep", 256'(pll_mode[5:4]), 256'(2));
        do_read('hA0, "R4 mode upper bits zero");
        do_write('hA0, 32'h000C_0004);
        check(pll_mode === 8'h64, "R4 field 1 normal kept", 256'(pll_mode), 256'(8'h64));
        do_write('hA0, 32'h0030_0000);
        check(pll_mode === 8'h44, "R4 field 2 to slow", 256'(pll_mode), 256'(8'h44));

        // R7: drive each soft-reset line on its own
        for (int n = 0; n < NR * 16; n++) begin
            logic [31:0] one;
            for (int k = 0; k < NR; k++) do_write('h400 + 4*k, 32'hFFFF_0000);
            do_write('h400 + 4*(n/16), {16'(1 << (n % 16)), 16'(1 << (n % 16))});
            one = 32'(1) << n;
            check(soft_rst === one, "R7 assert line", 256'(soft_rst), 256'(one));
            do_write('h400 + 4*(n/16), {16'(1 << (n % 16)), 16'h0});
            check(soft_rst === '0, "R7 release line", 256'(soft_rst), 256'(0));
        end

        // R9: a reset mid-run clears everything
        do_write('h300, 32'hFFFF_A5A5);
        do_write('h400, 32'hFFFF_00FF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        clear_model();
        check(rsp_valid === 1'b0, "R9 rsp_valid cleared", 256'(rsp_valid), 256'(0));
        check(rsp_rdata === 32'h0, "R9 rsp_rdata cleared", 256'(rsp_rdata), 256'(0));
        check_outputs();
        do_read('h0, "R9 pll word cleared");

        finish_run();
    end
endmodule